// File: doc/BRIEF.md
# DMA Channel Transfer Counter

This block keeps the running state of one DMA channel: how many transfers are left, which memory address the next transfer uses, and whether the channel is still armed. Software loads the count, the address and the arm bit through a small write port. The channel engine pulses a strobe once per completed data transfer. On each strobe the block steps the address by the transfer size and counts down. It raises a one-cycle done pulse when a block of transfers finishes.

Two counting modes are selected by a pin. In normal mode the full 16-bit count runs down. When the last transfer completes, the block disarms itself. In repeat mode the count splits in two. The low byte is the running count and the high byte is a reload value. When the low byte runs out it is refilled from the high byte, the address jumps back to where the block started, and the channel stays armed until software disarms it. Bus arbitration and the data path live elsewhere.

Top module: `dma_xfer_counter`

## Requirements
- R1: After a synchronous active-low reset, count_o, addr_o, enable_o and done_o are all zero.
- R2: A write with wr_en high takes effect at the next clock edge. The selector wr_sel picks the target: 0 loads count_o from wr_data[15:0]; 1 loads addr_o and the start shadow from wr_data; 2 loads enable_o from wr_data[0] and, when that bit is 1, copies the current addr_o into the start shadow; 3 changes no register.
- R3: In normal mode (repeat_mode=0) an accepted strobe decrements the 16-bit count by one. A count of 0 wraps to 16'hFFFF and the channel stays armed.
- R4: In normal mode a strobe accepted while the count is 1 leaves the count at 0, clears enable_o and raises done_o.
- R5: In repeat mode (repeat_mode=1) an accepted strobe decrements only count_o[7:0] and leaves count_o[15:8] unchanged. A low byte of 0 wraps to 8'hFF.
- R6: In repeat mode a strobe accepted while count_o[7:0] is 1 reloads count_o[7:0] from count_o[15:8], restores addr_o to the start shadow, raises done_o, and keeps enable_o set.
- R7: Every accepted strobe that is not a repeat reload advances addr_o by 1 when word_size=0 (byte) or by 2 when word_size=1 (word), modulo 2^ADDR_W.
- R8: A strobe while enable_o is 0 changes no output.
- R9: A strobe in the same cycle as any write (wr_en=1, any wr_sel) is discarded. Only the write takes effect.
- R10: An accepted strobe updates every output at the next clock edge. done_o is high for exactly the cycle after each finishing strobe and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 count, 1 address, 2 control, 3 none |
| wr_data | input | ADDR_W | Write data |
| xfer_stb | input | 1 | One pulse per completed data transfer |
| repeat_mode | input | 1 | 0 normal counting, 1 repeat counting |
| word_size | input | 1 | 0 byte transfers, 1 word transfers |
| addr_o | output | ADDR_W | Current memory address |
| count_o | output | 16 | Current count register |
| enable_o | output | 1 | Channel armed |
| done_o | output | 1 | One-cycle block-finished pulse |

## Verification
The hardest situation to reach is a repeat-mode reload after the address has moved away from the start shadow. This needs a small low byte, several accepted strobes, and no intervening write. The random stimulus therefore loads mostly tiny counts in both bytes and fires strobes in most cycles. That makes reloads and normal-mode terminal counts frequent. It also mixes in writes that coincide with strobes, and address loads near the top of the address space, so the wrap and write-priority cases occur without being scripted.

// File: rtl/dxc_pkg.sv
// Shared types for the DMA channel transfer counter.
// Assumes a 2-bit write selector and address steps of one or two bytes.
package dxc_pkg;
    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_ADDR  = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } dxc_sel_e;

    // Address step for one transfer of the selected size.
    function automatic logic [1:0] xfer_step(input logic word);
        return word ? 2'd2 : 2'd1;
    endfunction
endpackage

// File: rtl/dxc_count_unit.sv
// Count register of one channel.
// Normal mode: a single CNT_W-bit down counter.
// Repeat mode: the low half counts and the high half is the reload value.
// Assumes the caller has already masked strobes with enable and write priority.
module dxc_count_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             fire,
    input  logic             rpt,
    output logic [CNT_W-1:0] cnt,
    output logic             term
);
    localparam int HALF = CNT_W / 2;

    logic [HALF-1:0] lo;
    logic [HALF-1:0] hi;

    assign lo = cnt[HALF-1:0];
    assign hi = cnt[CNT_W-1:HALF];

    // Terminal detect on the pre-decrement value: this transfer finishes the block.
    always_comb begin
        if (rpt) term = (lo == HALF'(1));
        else     term = (cnt == CNT_W'(1));
    end

    // Count update: a load wins, then a reload or a decrement on an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (fire) begin
            if (rpt) begin
                if (term) cnt[HALF-1:0] <= hi;
                else      cnt[HALF-1:0] <= lo - HALF'(1);
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    AST_NORMAL_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !ld && !rpt) |=> (cnt == $past(cnt) - CNT_W'(1))); // R3
    AST_RPT_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !ld && rpt) |=> (cnt[CNT_W-1:HALF] == $past(cnt[CNT_W-1:HALF]))); // R5
    AST_RPT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !ld && rpt && term) |=> (cnt[HALF-1:0] == $past(cnt[CNT_W-1:HALF]))); // R6
endmodule

// File: rtl/dxc_addr_unit.sv
// Memory address register and start shadow of one channel.
// The address steps by the transfer size on each accepted strobe.
// On a repeat reload it returns to the shadow instead of stepping.
// Assumes load and strobe are never both active (the top gives loads priority).
module dxc_addr_unit #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              snap,
    input  logic              fire,
    input  logic              restore,
    input  logic              word,
    output logic [ADDR_W-1:0] addr
);
    import dxc_pkg::*;

    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] stepped;

    // Next sequential address for one transfer of the current size.
    assign stepped = addr + ADDR_W'(xfer_step(word));

    // Address register: load, restore on reload, or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (ld) begin
            addr <= ld_val;
        end else if (fire) begin
            addr <= restore ? start_q : stepped;
        end
    end

    // Start shadow: follows address loads and snapshots the address when the channel is armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (ld) begin
            start_q <= ld_val;
        end else if (snap) begin
            start_q <= addr;
        end
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !ld && !restore) |=> (addr == $past(addr) + ADDR_W'(xfer_step($past(word))))); // R7
    AST_ADDR_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !ld && restore) |=> (addr == $past(start_q))); // R6
endmodule

// File: rtl/dxc_enable_ctl.sv
// Arm bit and done pulse of one channel.
// Software sets or clears the arm bit; a normal-mode terminal transfer clears it.
// A terminal transfer in either mode raises a one-cycle done pulse.
module dxc_enable_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctl,
    input  logic wr_bit,
    input  logic fire,
    input  logic term,
    input  logic rpt,
    output logic en,
    output logic done
);
    // Arm bit: software write first, then the hardware clear at the end of a normal block.
    always_ff @(posedge clk) begin
        if (!rst_n)                   en <= 1'b0;
        else if (wr_ctl)              en <= wr_bit;
        else if (fire && term && !rpt) en <= 1'b0;
    end

    // Done pulse: registered terminal event, so it lasts one cycle per event.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= fire && term;
    end

    AST_EN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && term && !rpt && !wr_ctl) |=> !en); // R4
    AST_RPT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && rpt && !wr_ctl) |=> en); // R6
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire && term) |=> !done); // R10
endmodule

// File: rtl/dma_xfer_counter.sv
// Transfer count and address control for one DMA channel.
// Accepts a strobe only while armed and when no register write is in the same cycle.
// Assumes ADDR_W >= CNT_W so that a count write fits in the write data.
module dma_xfer_counter #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              xfer_stb,
    input  logic              repeat_mode,
    input  logic              word_size,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              enable_o,
    output logic              done_o
);
    import dxc_pkg::*;

    dxc_sel_e sel;
    logic     ld_cnt;
    logic     ld_addr;
    logic     ld_ctl;
    logic     arm_snap;
    logic     fire;
    logic     term;

    // Decode the write target; a write of any kind blocks the strobe.
    always_comb begin
        sel      = dxc_sel_e'(wr_sel);
        ld_cnt   = wr_en && (sel == SEL_COUNT);
        ld_addr  = wr_en && (sel == SEL_ADDR);
        ld_ctl   = wr_en && (sel == SEL_CTRL);
        arm_snap = ld_ctl && wr_data[0];
        fire     = xfer_stb && enable_o && !wr_en;
    end

    dxc_count_unit #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (ld_cnt),
        .ld_val (wr_data[CNT_W-1:0]),
        .fire   (fire),
        .rpt    (repeat_mode),
        .cnt    (count_o),
        .term   (term)
    );

    dxc_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (ld_addr),
        .ld_val  (wr_data),
        .snap    (arm_snap),
        .fire    (fire),
        .restore (term && repeat_mode),
        .word    (word_size),
        .addr    (addr_o)
    );

    dxc_enable_ctl u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ctl (ld_ctl),
        .wr_bit (wr_data[0]),
        .fire   (fire),
        .term   (term),
        .rpt    (repeat_mode),
        .en     (enable_o),
        .done   (done_o)
    );

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_o && !wr_en) |=> ($stable(count_o) && $stable(addr_o) && !enable_o)); // R8
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> (count_o == $past(wr_data[CNT_W-1:0]))); // R9
    AST_NONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> ($stable(count_o) && $stable(addr_o) && $stable(enable_o))); // R2
endmodule

// File: tb/test_dma_xfer_counter.sv
`timescale 1ns/100ps
module test_dma_xfer_counter;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [AW-1:0] wr_data = '0;
    logic          xfer_stb = 1'b0;
    logic          repeat_mode = 1'b0;
    logic          word_size = 1'b0;
    logic [AW-1:0] addr_o;
    logic [15:0]   count_o;
    logic          enable_o;
    logic          done_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Reference state, built from the requirements.
    logic [15:0]   m_cnt = '0;
    logic [AW-1:0] m_addr = '0;
    logic [AW-1:0] m_start = '0;
    logic          m_en = 1'b0;
    logic          m_done = 1'b0;
    string         m_tag = "R1";

    always #2.5 clk = ~clk;  // 200 MHz

    dma_xfer_counter #(.ADDR_W(AW), .CNT_W(16)) i_dma_xfer_counter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .xfer_stb(xfer_stb), .repeat_mode(repeat_mode), .word_size(word_size),
        .addr_o(addr_o), .count_o(count_o), .enable_o(enable_o), .done_o(done_o)
    );

    function automatic logic [AW-1:0] step_of(input logic w);
        return w ? AW'(2) : AW'(1);
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    // Advance the reference by one clock using the inputs applied in this cycle.
    task automatic model_step();
        logic       fire;
        logic [7:0] lo;
        m_done = 1'b0;
        fire = xfer_stb && m_en && !wr_en;
        if (wr_en) begin
            m_tag = xfer_stb ? "R9" : "R2";
            case (wr_sel)
                2'd0: m_cnt = wr_data[15:0];
                2'd1: begin m_addr = wr_data; m_start = wr_data; end
                2'd2: begin m_en = wr_data[0]; if (wr_data[0]) m_start = m_addr; end
                default: ;
            endcase
        end else if (fire) begin
            if (repeat_mode) begin
                lo = m_cnt[7:0];
                if (lo == 8'd1) begin
                    m_cnt[7:0] = m_cnt[15:8]; m_addr = m_start; m_done = 1'b1; m_tag = "R6";
                end else begin
                    m_cnt[7:0] = lo - 8'd1; m_addr = m_addr + step_of(word_size); m_tag = "R5";
                end
            end else begin
                m_cnt = m_cnt - 16'd1;
                m_addr = m_addr + step_of(word_size);
                if (m_cnt == 16'd0) begin m_en = 1'b0; m_done = 1'b1; m_tag = "R4"; end
                else m_tag = "R3";
            end
        end else begin
            m_tag = xfer_stb ? "R8" : "R10";
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "count", 32'(count_o), 32'(m_cnt));
        chk(tag, "addr", 32'(addr_o), 32'(m_addr));
        chk(tag, "enable", 32'(enable_o), 32'(m_en));
        chk(tag == "R6" || tag == "R4" ? tag : "R10", "done", 32'(done_o), 32'(m_done));
    endtask

    // One clock: drive at the falling edge, update the model at the rising edge, check 2 ns later.
    task automatic cyc(input logic we, input logic [1:0] sel, input logic [AW-1:0] d, input logic stb, input string hint);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = d; xfer_stb = stb;
        @(posedge clk);
        model_step();
        #2;
        compare_all(hint == "" ? m_tag : hint);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        compare_all("R1");
        @(negedge clk);
        rst_n = 1'b1;

        // Directed: normal mode, word size, address wrap, terminal count, idle strobe.
        repeat_mode = 1'b0; word_size = 1'b1;
        cyc(1, 2'd0, AW'(16'h0002), 0, "R2");
        cyc(1, 2'd1, AW'('hFFFFFE), 0, "R2");
        cyc(1, 2'd2, AW'(1), 1, "R9");
        cyc(0, 2'd0, '0, 1, "R7");
        cyc(0, 2'd0, '0, 1, "R4");
        cyc(0, 2'd0, '0, 1, "R8");
        // Directed: normal wrap from zero.
        cyc(1, 2'd2, AW'(1), 0, "R2");
        cyc(0, 2'd0, '0, 1, "R3");
        // Directed: repeat mode with reload 2, start 0x100, byte size.
        repeat_mode = 1'b1; word_size = 1'b0;
        cyc(1, 2'd0, AW'(16'h0202), 0, "R2");
        cyc(1, 2'd1, AW'('h100), 0, "R2");
        cyc(0, 2'd0, '0, 1, "R5");
        cyc(0, 2'd0, '0, 1, "R6");
        cyc(0, 2'd0, '0, 1, "R5");
        cyc(1, 2'd3, AW'('h55), 1, "R9");
        cyc(0, 2'd0, '0, 1, "R6");
        cyc(1, 2'd2, AW'(0), 0, "R2");
        cyc(0, 2'd0, '0, 1, "R8");

        // Constrained random.
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [AW-1:0] d;
            logic [1:0] s;
            logic we;
            r = int'($urandom_range(0, 99));
            we = 1'b1;
            if (r < 10) begin
                s = 2'd0;
                d = ($urandom_range(0, 9) == 0) ? AW'($urandom) :
                    AW'({8'($urandom_range(0, 4)), 8'($urandom_range(0, 4))});
            end else if (r < 15) begin
                s = 2'd1;
                d = ($urandom_range(0, 3) == 0) ? AW'('hFFFFFF - $urandom_range(0, 5)) : AW'($urandom);
            end else if (r < 23) begin
                s = 2'd2;
                d = AW'($urandom_range(0, 5) != 0);
            end else if (r < 25) begin
                s = 2'd3;
                d = AW'($urandom);
            end else begin
                we = 1'b0; s = 2'd0; d = '0;
            end
            if ($urandom_range(0, 49) == 0) repeat_mode = ~repeat_mode;
            word_size = 1'($urandom);
            cyc(we, s, d, $urandom_range(0, 9) < 7, "");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule